// File: doc/BRIEF.md
# NAND Read-Retry Parameter Sequencer

This block switches a multi-level-cell NAND device into one of several read-retry modes. A start pulse together with a mode index opens a short programming transaction on a command/address/data cycle interface. A lower-level bus PHY carries out each cycle and acknowledges it with a ready handshake.

The transaction has three parts. A command cycle first opens the device's private parameter space. Then, for every vendor register, an address cycle carries the register's offset and a data cycle carries the value for the chosen mode. A final command cycle makes the new settings take effect. The per-mode values come from an internal table with one entry per register per mode. Loading that table is the job of other logic, through a simple write port.

The PHY can flag a failed cycle. When it does, the transaction stops at once, and the block reports the result on a one-clock done pulse with an error flag.

Top module: `rr_param_seq`

## Requirements
- R1: After an accepted start with a valid mode, the first bus cycle is a command cycle (type 2'b00) carrying byte 8'h36.
- R2: After that opening command, every register i from 0 to NREGS-1 takes exactly two cycles, in ascending order of i: an address cycle (type 2'b01) carrying its offset, then a data-out cycle (type 2'b10) carrying its value.
- R3: The last cycle is a command cycle carrying 8'h16. One clock after the PHY accepts it, done is high and error is low.
- R4: For mode m, register i takes the table entry at index m*NREGS+i.
- R5: With the default offset option, the offsets for registers 0 through 7 are 8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE and 8'hAF.
- R6: If cyc_err is high in the cycle where the PHY accepts a cycle, no further bus cycle is issued. In the next clock, done and error are both high, and the apply command is skipped unless it was the cycle that failed.
- R7: A start with a mode index at or above NMODES issues no bus cycle, and done and error are both high in the clock after start.
- R8: While cyc_valid is high and cyc_ready is low, cyc_valid, cyc_type and cyc_byte hold their values.
- R9: A start that arrives while a transaction is running has no effect on that transaction, and it does not begin a new one.
- R10: done is high for exactly one clock per transaction.
- R11: A write with tbl_we high stores tbl_wdata at table index tbl_waddr. Later transactions use the stored value.
- R12: After reset, cyc_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a transaction when idle |
| mode | input | MODE_W | Requested read-retry mode |
| tbl_we | input | 1 | Value table write enable |
| tbl_waddr | input | AW | Value table write index |
| tbl_wdata | input | 8 | Value table write byte |
| cyc_valid | output | 1 | A bus cycle is offered to the PHY |
| cyc_type | output | 2 | 00 command, 01 address, 10 data-out |
| cyc_byte | output | 8 | Byte carried by the cycle |
| cyc_ready | input | 1 | PHY accepts the offered cycle |
| cyc_err | input | 1 | PHY reports the accepted cycle failed |
| done | output | 1 | One-clock end-of-transaction pulse |
| error | output | 1 | Transaction failed or was rejected; valid with done |

## Verification
The bench builds the block with NREGS=8, NMODES=5 and MODE_W=3. A three-bit mode port can then carry the indices 5, 6 and 7, so the rejection of an out-of-range mode can be driven directly, while all eight default offsets still appear in every transaction. The table holds 40 entries, and the bench fills each with a distinct computed byte. A wrong base index or a wrong register order would therefore show up as a wrong data byte. The PHY model in the bench varies its ready delay and injects failures on the opening command, on a middle address cycle and on the apply command.

// File: rtl/rr_seq_pkg.sv
package rr_seq_pkg;

   typedef enum logic [1:0] {
      CYC_CMD  = 2'b00,
      CYC_ADDR = 2'b01,
      CYC_DATA = 2'b10
   } cyc_kind_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ENTER,
      S_ADDR,
      S_DATA,
      S_APPLY,
      S_FIN
   } seq_state_e;

   localparam logic [7:0] CMD_OPEN  = 8'h36;
   localparam logic [7:0] CMD_APPLY = 8'h16;
   localparam int         STD_OFFSET_COUNT = 8;

   function automatic logic [7:0] std_offset(input int idx);
      case (idx)
         0: return 8'hCC;
         1: return 8'hBF;
         2: return 8'hAA;
         3: return 8'hAB;
         4: return 8'hCD;
         5: return 8'hAD;
         6: return 8'hAE;
         7: return 8'hAF;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/rr_offset_src.sv
module rr_offset_src #(
   parameter int         NREGS    = 8,
   parameter bit         USE_STD  = 1'b1,
   parameter logic [7:0] ALT_BASE = 8'hA0,
   parameter int         IW       = 3
) (
   input  logic [IW-1:0] idx,
   output logic [7:0]    off
);
   import rr_seq_pkg::*;

   generate
      if (USE_STD) begin : g_std
         if (NREGS > STD_OFFSET_COUNT) begin : g_bad
            $error("default offset list holds only eight registers");
         end
         always_comb off = std_offset(int'(idx));
      end else begin : g_alt
         always_comb off = ALT_BASE + 8'(idx);
      end
   endgenerate

endmodule

// File: rtl/rr_value_table.sv
module rr_value_table #(
   parameter int DEPTH = 64,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && int'(waddr) < DEPTH) mem[waddr] <= wdata;
   end

   always_comb begin
      rdata = 8'h00;
      if (int'(raddr) < DEPTH) rdata = mem[raddr];
   end

endmodule

// File: rtl/rr_seq_ctrl.sv
module rr_seq_ctrl #(
   parameter int NREGS  = 8,
   parameter int NMODES = 8,
   parameter int MODE_W = 4,
   parameter int AW     = 6,
   parameter int IW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MODE_W-1:0] mode,
   input  logic              cyc_ready,
   input  logic              cyc_err,
   input  logic [7:0]        off_byte,
   input  logic [7:0]        val_byte,
   output logic [IW-1:0]     reg_idx,
   output logic [AW-1:0]     base,
   output logic              cyc_valid,
   output logic [1:0]        cyc_type,
   output logic [7:0]        cyc_byte,
   output logic              done,
   output logic              error
);
   import rr_seq_pkg::*;

   localparam logic [IW-1:0] LAST_IDX = IW'(NREGS - 1);

   seq_state_e state;
   logic       err_q;
   logic       take;

   assign take = cyc_valid && cyc_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         err_q   <= 1'b0;
         reg_idx <= '0;
         base    <= '0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               reg_idx <= '0;
               base    <= AW'(int'(mode) * NREGS);
               if (int'(mode) >= NMODES) begin
                  err_q <= 1'b1;
                  state <= S_FIN;
               end else begin
                  err_q <= 1'b0;
                  state <= S_ENTER;
               end
            end
            S_ENTER: if (take) begin
               if (cyc_err) begin
                  err_q <= 1'b1;
                  state <= S_FIN;
               end else state <= S_ADDR;
            end
            S_ADDR: if (take) begin
               if (cyc_err) begin
                  err_q <= 1'b1;
                  state <= S_FIN;
               end else state <= S_DATA;
            end
            S_DATA: if (take) begin
               if (cyc_err) begin
                  err_q <= 1'b1;
                  state <= S_FIN;
               end else if (reg_idx == LAST_IDX) begin
                  state <= S_APPLY;
               end else begin
                  reg_idx <= reg_idx + 1'b1;
                  state   <= S_ADDR;
               end
            end
            S_APPLY: if (take) begin
               err_q <= cyc_err;
               state <= S_FIN;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      cyc_valid = 1'b1;
      cyc_type  = CYC_CMD;
      cyc_byte  = 8'h00;
      case (state)
         S_ENTER: cyc_byte = CMD_OPEN;
         S_ADDR: begin
            cyc_type = CYC_ADDR;
            cyc_byte = off_byte;
         end
         S_DATA: begin
            cyc_type = CYC_DATA;
            cyc_byte = val_byte;
         end
         S_APPLY: cyc_byte = CMD_APPLY;
         default: cyc_valid = 1'b0;
      endcase
   end

   assign done  = (state == S_FIN);
   assign error = done && err_q;

   p_open_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cyc_valid) |-> (cyc_type == CYC_CMD && cyc_byte == CMD_OPEN));

   p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && cyc_ready && cyc_err) |=> (done && error && !cyc_valid));

   p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && start && int'(mode) >= NMODES) |=> (done && error));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && !cyc_ready) |=> (cyc_valid && $stable(cyc_type) && $stable(cyc_byte)));

   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && !cyc_ready && start) |=> cyc_valid);

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/rr_param_seq.sv
module rr_param_seq #(
   parameter int         NREGS    = 8,
   parameter int         NMODES   = 8,
   parameter int         MODE_W   = 4,
   parameter bit         USE_STD  = 1'b1,
   parameter logic [7:0] ALT_BASE = 8'hA0,
   parameter int         DEPTH    = NREGS * NMODES,
   parameter int         AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MODE_W-1:0] mode,
   input  logic              tbl_we,
   input  logic [AW-1:0]     tbl_waddr,
   input  logic [7:0]        tbl_wdata,
   output logic              cyc_valid,
   output logic [1:0]        cyc_type,
   output logic [7:0]        cyc_byte,
   input  logic              cyc_ready,
   input  logic              cyc_err,
   output logic              done,
   output logic              error
);
   localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

   if (NREGS < 1 || NMODES < 1) begin : g_bad_size
      $error("register and mode counts must be positive");
   end
   if ((1 << MODE_W) < NMODES) begin : g_bad_mode_w
      $error("mode port too narrow for the mode count");
   end
   if (DEPTH != NREGS * NMODES) begin : g_bad_depth
      $error("table depth must equal registers times modes");
   end

   logic [IW-1:0] reg_idx;
   logic [AW-1:0] base;
   logic [AW-1:0] raddr;
   logic [7:0]    off_byte;
   logic [7:0]    val_byte;

   assign raddr = base + AW'(reg_idx);

   rr_offset_src #(
      .NREGS(NREGS), .USE_STD(USE_STD), .ALT_BASE(ALT_BASE), .IW(IW)
   ) u_off (
      .idx(reg_idx),
      .off(off_byte)
   );

   rr_value_table #(.DEPTH(DEPTH), .AW(AW)) u_tbl (
      .clk  (clk),
      .we   (tbl_we),
      .waddr(tbl_waddr),
      .wdata(tbl_wdata),
      .raddr(raddr),
      .rdata(val_byte)
   );

   rr_seq_ctrl #(
      .NREGS(NREGS), .NMODES(NMODES), .MODE_W(MODE_W), .AW(AW), .IW(IW)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .mode     (mode),
      .cyc_ready(cyc_ready),
      .cyc_err  (cyc_err),
      .off_byte (off_byte),
      .val_byte (val_byte),
      .reg_idx  (reg_idx),
      .base     (base),
      .cyc_valid(cyc_valid),
      .cyc_type (cyc_type),
      .cyc_byte (cyc_byte),
      .done     (done),
      .error    (error)
   );

endmodule

// File: tb/rr_param_seq_bench.sv
module rr_param_seq_bench;
   localparam int NREGS  = 8;
   localparam int NMODES = 5;
   localparam int MODE_W = 3;
   localparam int DEPTH  = NREGS * NMODES;
   localparam int AW     = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [MODE_W-1:0] mode = '0;
   logic tbl_we = 1'b0;
   logic [AW-1:0] tbl_waddr = '0;
   logic [7:0] tbl_wdata = '0;
   logic cyc_valid;
   logic [1:0] cyc_type;
   logic [7:0] cyc_byte;
   logic cyc_ready = 1'b0;
   logic cyc_err = 1'b0;
   logic done;
   logic error;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   byte unsigned tbl_model [DEPTH];

   always #10 clk = ~clk;

   rr_param_seq #(.NREGS(NREGS), .NMODES(NMODES), .MODE_W(MODE_W)) u_rr_param_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
      .cyc_valid(cyc_valid), .cyc_type(cyc_type), .cyc_byte(cyc_byte),
      .cyc_ready(cyc_ready), .cyc_err(cyc_err), .done(done), .error(error)
   );

   function automatic byte unsigned ref_offset(input int i);
      byte unsigned lst [8] = '{8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE, 8'hAF};
      return lst[i];
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic write_tbl(input int idx, input byte unsigned v);
      @(negedge clk);
      tbl_we = 1'b1; tbl_waddr = AW'(idx); tbl_wdata = v;
      tbl_model[idx] = v;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   // fail_at < 0 means no failure; poke drives start while busy (R9)
   task automatic run(input int m, input int fail_at, input int gap, input bit poke);
      int exp_t[$];
      int exp_b[$];
      string exp_tag[$];
      int n = 0;
      int waitc = 0;
      int loops = 0;
      bit fin = 0;
      bit bad = (m >= NMODES);
      bit exp_err;
      int exp_n;
      if (!bad) begin
         exp_t.push_back(0); exp_b.push_back(8'h36); exp_tag.push_back("R1");
         for (int i = 0; i < NREGS; i++) begin
            exp_t.push_back(1); exp_b.push_back(ref_offset(i)); exp_tag.push_back("R5/R2 addr");
            exp_t.push_back(2); exp_b.push_back(tbl_model[m*NREGS+i]); exp_tag.push_back("R4/R11 data");
         end
         exp_t.push_back(0); exp_b.push_back(8'h16); exp_tag.push_back("R3");
      end
      exp_err = bad || (fail_at >= 0);
      exp_n   = bad ? 0 : ((fail_at >= 0) ? fail_at + 1 : exp_t.size());
      @(negedge clk);
      start = 1'b1; mode = MODE_W'(m);
      @(negedge clk);
      start = 1'b0;
      while (!fin && loops < 2000) begin
         loops++;
         if (done) begin
            check(error == exp_err, bad ? "R7 error" : (fail_at >= 0 ? "R6 error" : "R3 error"),
                  int'(error), int'(exp_err));
            check(n == exp_n, bad ? "R7 cycle count" : "R6/R2 cycle count", n, exp_n);
            check(!cyc_valid, "R6 no cycle at done", int'(cyc_valid), 0);
            fin = 1;
         end else if (cyc_valid) begin
            if (n >= exp_t.size() || n >= exp_n) begin
               check(1'b0, "R6/R7 unexpected cycle", int'(cyc_byte), 0);
               fin = 1;
            end else begin
               check(int'(cyc_type) == exp_t[n], {exp_tag[n], " type R8"}, int'(cyc_type), exp_t[n]);
               check(int'(cyc_byte) == exp_b[n], exp_tag[n], int'(cyc_byte), exp_b[n]);
               if (poke) begin start = 1'b1; mode = MODE_W'(NMODES); end
               if (waitc < gap) begin
                  waitc++;
               end else begin
                  cyc_ready = 1'b1;
                  cyc_err = (n == fail_at);
                  n++;
                  waitc = 0;
               end
            end
         end else begin
            check(1'b0, "R10 idle before done", 0, 1);
            fin = 1;
         end
         @(negedge clk);
         cyc_ready = 1'b0; cyc_err = 1'b0; start = 1'b0;
      end
      check(fin, "R10 done seen", int'(fin), 1);
      check(!done, "R10 done one clock", int'(done), 0);
      check(!cyc_valid, "R9 no restart", int'(cyc_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!cyc_valid, "R12 valid", int'(cyc_valid), 0);
      check(!done, "R12 done", int'(done), 0);
      rst_n = 1'b1;
      for (int i = 0; i < DEPTH; i++) write_tbl(i, byte'((i * 37 + 11) ^ 8'h5A));
      run(0, -1, 0, 1'b0);
      run(3, -1, 2, 1'b0);
      run(4, -1, 1, 1'b1);
      run(5, -1, 0, 1'b0);
      run(7, -1, 0, 1'b0);
      run(1, 0, 0, 1'b0);
      run(2, 5, 1, 1'b0);
      run(2, 2 * NREGS + 1, 0, 1'b0);
      write_tbl(1 * NREGS + 3, 8'hE7);
      run(1, -1, 0, 1'b0);
      run(2, -1, 3, 1'b1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule